// File: doc/BRIEF.md
# DMA Channel Control/Status Unit

This unit is the register front end of a single descriptor-driven DMA channel. Software reaches it over a plain 32-bit register port with a combinational read path and a single-cycle write strobe. Through it, software turns the channel on and off, asks the engine to resume and re-read the chain's next pointer, loads the address of the next descriptor and reads back the address of the descriptor the engine is working on.

The data mover is not part of the unit. It appears only as inputs: a busy level, its current descriptor address, an acknowledge for the resume request, and single-cycle event pulses for end of transfer, end of chain and four error kinds. Each event is caught in a sticky status bit that software clears by writing a 1 to it. Three interrupt lines are derived from those bits: one for end of transfer, one for end of chain, and one shared by all error kinds.

Top module: `dma_chan_csr`

## Requirements
- R1: After a synchronous reset, chan_enable, append_req, next_desc, every sticky status bit and all three interrupt outputs are 0.
- R2: A write to offset 0x00 loads wdata bit 0 into the enable, which drives chan_enable one edge later. Reading 0x00 returns the enable in bit 0 and the pending append request in bit 1, with all other bits 0.
- R3: A write to 0x00 with bits 1 and 0 both set while the channel is already enabled raises append_req on the next edge. The request holds until the edge on which eng_append_ack is high. A new request written in the same cycle as the acknowledge wins. The request is ignored while the channel is disabled, and a write that clears bit 0 also drops any pending request.
- R4: Each event pulse sets its sticky status bit at 0x04 on the next edge: end of transfer at bit 12, end of chain at bit 11, internal parity error at bit 9, memory controller abort at bit 5, internal target abort at bit 4, internal master abort at bit 3. The bit then stays set.
- R5: A write to 0x04 clears each sticky bit whose position holds a 1 in wdata and leaves bits written 0 unchanged. An event arriving in the same cycle as its clear leaves the bit set.
- R6: Status bit 13 shows eng_busy in the same cycle, with no register in the path. Writes cannot change it.
- R7: irq_eot follows status bit 12 and irq_eoc follows status bit 11. irq_err is the OR of status bits 9, 5, 4 and 3.
- R8: Reading 0x08 returns eng_cur_desc in the same cycle. Writes to 0x08 have no effect.
- R9: A write to 0x24 loads the full 32-bit word into next_desc, which drives the output one edge later. Reading 0x24 returns it.
- R10: Reads of any offset other than 0x00, 0x04, 0x08 and 0x24 return 0, and writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (8) | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| eng_busy | input | 1 | Engine is processing descriptors |
| eng_cur_desc | input | 32 | Address of the descriptor in progress |
| eng_append_ack | input | 1 | Engine has taken the append request |
| evt_eot | input | 1 | End-of-transfer pulse |
| evt_eoc | input | 1 | End-of-chain pulse |
| evt_par_err | input | 1 | Internal parity error pulse |
| evt_mcu_abort | input | 1 | Memory controller abort pulse |
| evt_tgt_abort | input | 1 | Internal target abort pulse |
| evt_mst_abort | input | 1 | Internal master abort pulse |
| chan_enable | output | 1 | Channel enable to the engine |
| append_req | output | 1 | Pending resume/re-read request |
| next_desc | output | 32 | Next descriptor address to the engine |
| irq_eot | output | 1 | End-of-transfer interrupt |
| irq_eoc | output | 1 | End-of-chain interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
Writes to control, next-descriptor and status, like event pulses and the acknowledge, take effect on the first rising edge after they are presented. The interrupt lines change on that same edge. The busy bit and the current-descriptor readback follow their inputs within the same cycle. The bench drives inputs just after a falling edge, steps a behavioural model on each rising edge, and compares every output and the read data for the current address at the following falling edge. In this way every one-edge result and every same-cycle result is sampled exactly where it is due.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int CSR_DW = 32;

    // register offsets (byte addresses)
    localparam logic [31:0] OFS_CTRL = 32'h0000_0000;
    localparam logic [31:0] OFS_STAT = 32'h0000_0004;
    localparam logic [31:0] OFS_CUR  = 32'h0000_0008;
    localparam logic [31:0] OFS_NEXT = 32'h0000_0024;

    // control word fields
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_APP_BIT = 1;

    // status word: live busy flag
    localparam int ST_BUSY_BIT = 13;

    // sticky event indices (packed order of evt_t, LSB first)
    localparam int NUM_EVT = 6;
    localparam int EV_MABT = 0;
    localparam int EV_TABT = 1;
    localparam int EV_MCU  = 2;
    localparam int EV_PAR  = 3;
    localparam int EV_EOC  = 4;
    localparam int EV_EOT  = 5;
    localparam int NUM_ERR = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_CUR,
        SEL_NEXT
    } csr_sel_e;

    typedef struct packed {
        logic eot;
        logic eoc;
        logic par;
        logic mcu;
        logic tabt;
        logic mabt;
    } evt_t;

    // status word position of each sticky event
    function automatic int evt_bitpos(input int idx);
        case (idx)
            EV_MABT: return 3;
            EV_TABT: return 4;
            EV_MCU:  return 5;
            EV_PAR:  return 9;
            EV_EOC:  return 11;
            default: return 12;
        endcase
    endfunction

    function automatic csr_sel_e decode_ofs(input logic [31:0] ofs);
        if (ofs == OFS_CTRL)      return SEL_CTRL;
        else if (ofs == OFS_STAT) return SEL_STAT;
        else if (ofs == OFS_CUR)  return SEL_CUR;
        else if (ofs == OFS_NEXT) return SEL_NEXT;
        else                      return SEL_NONE;
    endfunction

endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  logic wr_en_bit,
    input  logic wr_app_bit,
    input  logic eng_append_ack,
    output logic enable_q,
    output logic append_q
);

    logic app_set;
    logic app_drop;

    // a new request needs the channel already on and kept on by this write
    assign app_set  = ctl_wr && wr_en_bit && wr_app_bit && enable_q;
    assign app_drop = (ctl_wr && !wr_en_bit) || eng_append_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= 1'b0;
            append_q <= 1'b0;
        end else begin
            if (ctl_wr) begin
                enable_q <= wr_en_bit;
            end
            if (ctl_wr && !wr_en_bit) begin
                append_q <= 1'b0;
            end else if (app_set) begin
                append_q <= 1'b1;
            end else if (app_drop) begin
                append_q <= 1'b0;
            end
        end
    end

    AST_APPEND_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        append_q |-> enable_q); // R3
    AST_APPEND_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        (append_q && eng_append_ack && !ctl_wr) |=> !append_q); // R3
    AST_DISABLED_NO_APPEND: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !enable_q) |=> !append_q); // R3
    AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (enable_q == $past(wr_en_bit))); // R2
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> $stable(enable_q)); // R2

endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status
    import dma_csr_pkg::*;
#(
    parameter int N_EVT = NUM_EVT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_EVT-1:0]     evt_in,
    input  logic [N_EVT-1:0]     evt_clr,
    input  logic                 busy,
    output logic [CSR_DW-1:0]    stat_word,
    output logic                 irq_eot,
    output logic                 irq_eoc,
    output logic                 irq_err
);

    logic [N_EVT-1:0] sticky_q;

    for (genvar g = 0; g < N_EVT; g++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst) begin
                sticky_q[g] <= 1'b0;
            end else begin
                // event has priority over a clear in the same cycle
                sticky_q[g] <= (sticky_q[g] && !evt_clr[g]) || evt_in[g];
            end
        end

        AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
            evt_in[g] |=> sticky_q[g]); // R4
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
            (sticky_q[g] && !evt_clr[g]) |=> sticky_q[g]); // R5
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (evt_clr[g] && !evt_in[g]) |=> !sticky_q[g]); // R5
    end

    always_comb begin
        stat_word = '0;
        for (int i = 0; i < N_EVT; i++) begin
            stat_word[evt_bitpos(i)] = sticky_q[i];
        end
        stat_word[ST_BUSY_BIT] = busy;
    end

    assign irq_eot = sticky_q[EV_EOT];
    assign irq_eoc = sticky_q[EV_EOC];
    assign irq_err = |sticky_q[NUM_ERR-1:0];

endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux
    import dma_csr_pkg::*;
(
    input  csr_sel_e             sel,
    input  logic                 enable_q,
    input  logic                 append_q,
    input  logic [CSR_DW-1:0]    stat_word,
    input  logic [CSR_DW-1:0]    cur_desc,
    input  logic [CSR_DW-1:0]    next_desc,
    output logic [CSR_DW-1:0]    rdata
);

    logic [CSR_DW-1:0] ctrl_word;

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTL_EN_BIT]  = enable_q;
        ctrl_word[CTL_APP_BIT] = append_q;
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rdata = ctrl_word;
            SEL_STAT: rdata = stat_word;
            SEL_CUR:  rdata = cur_desc;
            SEL_NEXT: rdata = next_desc;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 eng_busy,
    input  logic [31:0]          eng_cur_desc,
    input  logic                 eng_append_ack,
    input  logic                 evt_eot,
    input  logic                 evt_eoc,
    input  logic                 evt_par_err,
    input  logic                 evt_mcu_abort,
    input  logic                 evt_tgt_abort,
    input  logic                 evt_mst_abort,
    output logic                 chan_enable,
    output logic                 append_req,
    output logic [31:0]          next_desc,
    output logic                 irq_eot,
    output logic                 irq_eoc,
    output logic                 irq_err
);

    csr_sel_e             sel;
    logic                 ctl_wr;
    logic                 stat_wr;
    logic                 next_wr;
    evt_t                 evt;
    logic [NUM_EVT-1:0]   evt_vec;
    logic [NUM_EVT-1:0]   evt_clr;
    logic [CSR_DW-1:0]    stat_word;
    logic [CSR_DW-1:0]    next_q;
    logic                 err_any;

    assign sel     = decode_ofs(32'(reg_addr));
    assign ctl_wr  = reg_wr && (sel == SEL_CTRL);
    assign stat_wr = reg_wr && (sel == SEL_STAT);
    assign next_wr = reg_wr && (sel == SEL_NEXT);

    assign evt = '{eot:  evt_eot,
                   eoc:  evt_eoc,
                   par:  evt_par_err,
                   mcu:  evt_mcu_abort,
                   tabt: evt_tgt_abort,
                   mabt: evt_mst_abort};
    assign evt_vec = evt;
    assign err_any = |evt_vec[NUM_ERR-1:0];

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_clr
        assign evt_clr[g] = stat_wr && reg_wdata[evt_bitpos(g)];
    end

    dma_csr_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .ctl_wr         (ctl_wr),
        .wr_en_bit      (reg_wdata[CTL_EN_BIT]),
        .wr_app_bit     (reg_wdata[CTL_APP_BIT]),
        .eng_append_ack (eng_append_ack),
        .enable_q       (chan_enable),
        .append_q       (append_req)
    );

    dma_csr_status #(.N_EVT(NUM_EVT)) u_status (
        .clk       (clk),
        .rst       (rst),
        .evt_in    (evt_vec),
        .evt_clr   (evt_clr),
        .busy      (eng_busy),
        .stat_word (stat_word),
        .irq_eot   (irq_eot),
        .irq_eoc   (irq_eoc),
        .irq_err   (irq_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_q <= '0;
        end else if (next_wr) begin
            next_q <= reg_wdata;
        end
    end
    assign next_desc = next_q;

    dma_csr_rdmux u_rdmux (
        .sel       (sel),
        .enable_q  (chan_enable),
        .append_q  (append_req),
        .stat_word (stat_word),
        .cur_desc  (eng_cur_desc),
        .next_desc (next_q),
        .rdata     (reg_rdata)
    );

    AST_NEXT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !next_wr |=> $stable(next_desc)); // R9
    AST_NEXT_LOAD: assert property (@(posedge clk) disable iff (rst)
        next_wr |=> (next_desc == $past(reg_wdata))); // R9
    AST_IRQ_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_err) |-> $past(err_any)); // R7
    AST_IRQ_EOT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_eot) |-> $past(evt_eot)); // R7
    AST_IRQ_ERR_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_err) |-> $past(stat_wr)); // R7
    AST_BUSY_LIVE: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_STAT) |-> (reg_rdata[ST_BUSY_BIT] == eng_busy)); // R6

endmodule

// File: tb/dma_chan_csr_tb.sv
module dma_chan_csr_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_busy = 1'b0;
    logic [31:0] eng_cur_desc = '0;
    logic        eng_append_ack = 1'b0;
    logic        evt_eot = 1'b0, evt_eoc = 1'b0, evt_par_err = 1'b0;
    logic        evt_mcu_abort = 1'b0, evt_tgt_abort = 1'b0, evt_mst_abort = 1'b0;
    logic        chan_enable, append_req, irq_eot, irq_eoc, irq_err;
    logic [31:0] next_desc;

    int checks = 0;
    int failures = 0;
    bit live = 0;
    bit done = 0;

    // behavioural reference state
    bit          m_en, m_app;
    logic [31:0] m_stk, m_next;

    always #5 clk = ~clk;

    dma_chan_csr #(.ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
        .eng_cur_desc(eng_cur_desc), .eng_append_ack(eng_append_ack),
        .evt_eot(evt_eot), .evt_eoc(evt_eoc), .evt_par_err(evt_par_err),
        .evt_mcu_abort(evt_mcu_abort), .evt_tgt_abort(evt_tgt_abort),
        .evt_mst_abort(evt_mst_abort), .chan_enable(chan_enable),
        .append_req(append_req), .next_desc(next_desc), .irq_eot(irq_eot),
        .irq_eoc(irq_eoc), .irq_err(irq_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // model step on each rising edge
    always @(posedge clk) begin
        logic [31:0] clr, set;
        if (rst) begin
            m_en = 0; m_app = 0; m_stk = '0; m_next = '0;
            live = 1;
        end else begin
            if (reg_wr && reg_addr == 8'h00) begin
                if (!reg_wdata[0])                  m_app = 0;
                else if (reg_wdata[1] && m_en)      m_app = 1;
                else if (eng_append_ack)            m_app = 0;
                m_en = reg_wdata[0];
            end else if (eng_append_ack) begin
                m_app = 0;
            end
            clr = (reg_wr && reg_addr == 8'h04) ? reg_wdata : 32'h0;
            set = '0;
            set[12] = evt_eot; set[11] = evt_eoc; set[9] = evt_par_err;
            set[5] = evt_mcu_abort; set[4] = evt_tgt_abort; set[3] = evt_mst_abort;
            m_stk = (m_stk & ~clr & 32'h0000_1A38) | set;
            if (reg_wr && reg_addr == 8'h24) m_next = reg_wdata;
        end
    end

    // compare every falling edge
    always @(negedge clk) begin
        if (live) begin
            logic [31:0] exp_rd;
            string rtag;
            case (reg_addr)
                8'h00: begin exp_rd = {30'b0, m_app, m_en}; rtag = "R2 ctrl read"; end
                8'h04: begin exp_rd = m_stk | (32'(eng_busy) << 13); rtag = "R4 R5 R6 status read"; end
                8'h08: begin exp_rd = eng_cur_desc; rtag = "R8 current desc read"; end
                8'h24: begin exp_rd = m_next; rtag = "R9 next desc read"; end
                default: begin exp_rd = '0; rtag = "R10 unmapped read"; end
            endcase
            chk(rtag, reg_rdata, exp_rd);
            chk("R2 chan_enable", 32'(chan_enable), 32'(m_en));
            chk("R3 append_req", 32'(append_req), 32'(m_app));
            chk("R9 next_desc", next_desc, m_next);
            chk("R7 irq_eot", 32'(irq_eot), 32'(m_stk[12]));
            chk("R7 irq_eoc", 32'(irq_eoc), 32'(m_stk[11]));
            chk("R7 irq_err", 32'(irq_err), 32'(|{m_stk[9], m_stk[5], m_stk[4], m_stk[3]}));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk); #1;
        reg_addr = a;
    endtask

    task automatic pulse_evt(input logic [5:0] e);
        @(negedge clk); #1;
        {evt_eot, evt_eoc, evt_par_err, evt_mcu_abort, evt_tgt_abort, evt_mst_abort} = e;
        @(negedge clk); #1;
        {evt_eot, evt_eoc, evt_par_err, evt_mcu_abort, evt_tgt_abort, evt_mst_abort} = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 reset chan_enable", 32'(chan_enable), 32'h0);
        chk("R1 reset append_req", 32'(append_req), 32'h0);
        chk("R1 reset next_desc", next_desc, 32'h0);
        chk("R1 reset irqs", 32'({irq_eot, irq_eoc, irq_err}), 32'h0);
        rd(8'h04); rd(8'h00);

        // R2 enable, R3 append while disabled is ignored
        wr(8'h00, 32'h3);                 // disabled before: no append
        rd(8'h00);
        wr(8'h00, 32'h3);                 // enabled: append set
        rd(8'h00); rd(8'h00);
        @(negedge clk); #1; eng_append_ack = 1'b1;
        @(negedge clk); #1; eng_append_ack = 1'b0;
        wr(8'h00, 32'h3);
        wr(8'h00, 32'h0);                 // disable drops append
        wr(8'h00, 32'h1);
        @(negedge clk); #1;               // append and ack together: set wins
        reg_addr = 8'h00; reg_wr = 1'b1; reg_wdata = 32'h3; eng_append_ack = 1'b1;
        @(negedge clk); #1; reg_wr = 1'b0; eng_append_ack = 1'b0;
        rd(8'h00);

        // R4 each event, R7 irqs, R5 clears
        rd(8'h04);
        for (int i = 0; i < 6; i++) pulse_evt(6'(1 << i));
        wr(8'h04, 32'h0);                 // zeros leave bits
        wr(8'h04, 32'h0000_1000);         // clear EOT only
        wr(8'h04, 32'h0000_0038);         // clear three aborts
        @(negedge clk); #1;               // clear and event same cycle
        reg_addr = 8'h04; reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF; evt_par_err = 1'b1;
        @(negedge clk); #1; reg_wr = 1'b0; evt_par_err = 1'b0;
        wr(8'h04, 32'hFFFF_FFFF);

        // R6 busy live, R8 current descriptor
        rd(8'h04);
        @(negedge clk); #1; eng_busy = 1'b1;
        @(negedge clk); #1; wr(8'h04, 32'h0000_2000);
        @(negedge clk); #1; eng_busy = 1'b0;
        rd(8'h08);
        @(negedge clk); #1; eng_cur_desc = 32'hDEAD_BEE0;
        wr(8'h08, 32'h1234_5678);

        // R9 next descriptor, R10 unmapped
        wr(8'h24, 32'hCAFE_F00C);
        rd(8'h24);
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h10); rd(8'h24); rd(8'h00);

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            logic [7:0] addrs [7];
            addrs = '{8'h00, 8'h04, 8'h08, 8'h24, 8'h10, 8'h0C, 8'h01};
            @(negedge clk); #1;
            reg_addr = addrs[$urandom % 7];
            reg_wr = ($urandom % 3) == 0;
            reg_wdata = $urandom;
            if (reg_addr == 8'h00 && ($urandom % 2) == 0) reg_wdata[0] = 1'b1;
            eng_append_ack = ($urandom % 5) == 0;
            eng_busy = $urandom % 2;
            eng_cur_desc = $urandom;
            {evt_eot, evt_eoc, evt_par_err, evt_mcu_abort, evt_tgt_abort, evt_mst_abort} =
                6'($urandom) & 6'($urandom) & 6'($urandom);
        end
        @(negedge clk); #1;
        reg_wr = 1'b0; eng_append_ack = 1'b0;
        {evt_eot, evt_eoc, evt_par_err, evt_mcu_abort, evt_tgt_abort, evt_mst_abort} = '0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule